// File: doc/BRIEF.md
# Page-Buffered EEPROM Write Sequencer

This block sits behind a serial-memory bus engine and collects the data bytes of a write command in a small page buffer before anything touches the storage array. The bus engine first loads a start address. It then presents each received data byte with a one-cycle strobe. Each byte lands in the buffer slot selected by the low address bits. Only those low bits advance, so a long burst wraps inside its row and later bytes replace earlier ones at the same offset.

A commit pulse, which the bus engine raises when the write command closes correctly, copies every loaded slot into the array in one masked write. The block then holds a busy flag for a fixed, parameterised number of cycles that models the self-timed programming time. An abort pulse drops the buffered bytes without writing them. A commit with nothing loaded is harmless. The address pointer is visible so that the bus engine can serve a following current-address read. The array is a behavioural byte memory with an asynchronous read port. Every location starts at FFh.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset, busy and wr_en are 0, addr_ptr is 0, and every array location reads FFh.
- R2: An accepted byte strobe stores byte_data in buffer slot addr_ptr[PAGE_BITS-1:0]. It then adds 1 modulo 2^PAGE_BITS to the low PAGE_BITS bits of addr_ptr. The upper bits of addr_ptr do not change.
- R3: When more than 2^PAGE_BITS bytes are sent, the pointer wraps within the row. The last byte sent to a slot is the one written.
- R4: No array location changes, and wr_en stays 0, before a commit.
- R5: A commit with at least one slot loaded gives wr_en high for exactly one cycle, the cycle after the commit. In that cycle wr_row equals addr_ptr[ADDR_W-1:PAGE_BITS], wr_mask bit k is 1 exactly when slot k was loaded since the last load_addr, and wr_data[8k+7:8k] holds slot k. Only the masked locations change.
- R6: busy rises together with wr_en and stays high for exactly BUSY_CYCLES cycles.
- R7: A commit with no bytes loaded, or a commit that follows an abort, leaves the array unchanged and does not raise busy.
- R8: While busy is high, byte strobes, load_addr, commit and abort have no effect.
- R9: After a commit, addr_ptr holds the last written address plus one, with the wrap of R2.
- R10: A single-byte write changes exactly one array location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_addr | input | 1 | Load start_addr into the pointer and clear the buffer mask |
| start_addr | input | ADDR_W | Start address of a write command |
| byte_valid | input | 1 | Strobe for one data byte |
| byte_data | input | 8 | Data byte |
| commit | input | 1 | Copy the loaded bytes into the array |
| abort | input | 1 | Discard the loaded bytes |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Array read data (asynchronous) |
| busy | output | 1 | Self-timed write window active |
| addr_ptr | output | ADDR_W | Internal address pointer |
| wr_en | output | 1 | Array write strobe |
| wr_row | output | ADDR_W-PAGE_BITS | Row written |
| wr_mask | output | 2^PAGE_BITS | Per-byte write enables |
| wr_data | output | 8*2^PAGE_BITS | Page data, slot k in byte k |

## Verification
The assertions take the control strobes as single-cycle pulses. They also assume that when several strobes arrive in one idle cycle, the fixed priority applies: abort first, then commit, then load_addr, then byte_valid. The pointer-step property only holds when no higher-priority control is present with the byte strobe. The bench raises at most one control at a time while the block is idle. It only combines strobes deliberately inside a busy window, where all of them must be ignored. Every input changes on the falling clock edge.

// File: rtl/eepw_pkg.sv
package eepw_pkg;
  // Advance only the in-page bits of a pointer; the row bits are kept.
  function automatic int unsigned page_next(input int unsigned ptr, input int unsigned pbits);
    int unsigned low_m;
    low_m = (32'd1 << pbits) - 32'd1;
    return (ptr & ~low_m) | ((ptr + 32'd1) & low_m);
  endfunction

  // Row part of a byte address.
  function automatic int unsigned row_of(input int unsigned addr, input int unsigned pbits);
    return addr >> pbits;
  endfunction
endpackage

// File: rtl/eepw_page_buf.sv
module eepw_page_buf #(
  parameter int ADDR_W    = 11,
  parameter int PAGE_BITS = 4,
  localparam int PAGE     = 1 << PAGE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_go,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              byte_go,
  input  logic [7:0]        byte_data,
  input  logic              clear_go,
  output logic [ADDR_W-1:0] ptr,
  output logic [PAGE-1:0]   mask,
  output logic [PAGE*8-1:0] data_flat
);
  import eepw_pkg::*;

  logic [ADDR_W-1:0]    ptr_q;
  logic [PAGE-1:0]      mask_q;
  logic [PAGE_BITS-1:0] slot_sel;

  assign slot_sel = ptr_q[PAGE_BITS-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      mask_q <= '0;
    end else if (load_go) begin
      ptr_q  <= start_addr;
      mask_q <= '0;
    end else if (clear_go) begin
      mask_q <= '0;
    end else if (byte_go) begin
      ptr_q            <= ADDR_W'(page_next(32'(ptr_q), PAGE_BITS));
      mask_q[slot_sel] <= 1'b1;
    end
  end

  // One byte register per slot; the data is held through the busy window.
  for (genvar k = 0; k < PAGE; k++) begin : g_slot
    logic [7:0] slot_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        slot_q <= 8'hFF;
      else if (byte_go && slot_sel == PAGE_BITS'(k))
        slot_q <= byte_data;
    end
    assign data_flat[k*8 +: 8] = slot_q;
  end

  assign ptr  = ptr_q;
  assign mask = mask_q;
endmodule

// File: rtl/eepw_seq.sv
module eepw_seq #(
  parameter int ROW_W       = 7,
  parameter int PAGE        = 16,
  parameter int BUSY_CYCLES = 50000,
  localparam int CNT_W      = $clog2(BUSY_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [ROW_W-1:0] row_in,
  input  logic [PAGE-1:0]  mask_in,
  output logic             busy,
  output logic             wr_en,
  output logic [ROW_W-1:0] wr_row,
  output logic [PAGE-1:0]  wr_mask
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      wr_en   <= 1'b0;
      wr_row  <= '0;
      wr_mask <= '0;
    end else begin
      wr_en <= fire;
      if (fire) begin
        cnt_q   <= CNT_W'(BUSY_CYCLES);
        wr_row  <= row_in;
        wr_mask <= mask_in;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/eepw_array.sv
module eepw_array #(
  parameter int ADDR_W    = 11,
  parameter int PAGE_BITS = 4,
  localparam int PAGE     = 1 << PAGE_BITS,
  localparam int ROW_W    = ADDR_W - PAGE_BITS,
  localparam int DEPTH    = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ROW_W-1:0]  wr_row,
  input  logic [PAGE-1:0]   wr_mask,
  input  logic [PAGE*8-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < DEPTH; a++) mem[a] <= 8'hFF;
    end else if (wr_en) begin
      for (int k = 0; k < PAGE; k++)
        if (wr_mask[k]) mem[{wr_row, PAGE_BITS'(k)}] <= wr_data[k*8 +: 8];
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer #(
  parameter int ADDR_W      = 11,
  parameter int PAGE_BITS   = 4,
  parameter int BUSY_CYCLES = 50000,
  localparam int PAGE       = 1 << PAGE_BITS,
  localparam int ROW_W      = ADDR_W - PAGE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_addr,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              commit,
  input  logic              abort,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              busy,
  output logic [ADDR_W-1:0] addr_ptr,
  output logic              wr_en,
  output logic [ROW_W-1:0]  wr_row,
  output logic [PAGE-1:0]   wr_mask,
  output logic [PAGE*8-1:0] wr_data
);
  // Named internal events (also observed by the bound checker).
  logic            idle;
  logic            abort_go, commit_go, load_go, byte_go, commit_fire;
  logic            pend_any;
  logic [PAGE-1:0] pend_mask;

  // Priority while idle: abort, commit, load_addr, byte_valid.
  assign idle        = !busy;
  assign abort_go    = idle && abort;
  assign commit_go   = idle && commit && !abort;
  assign load_go     = idle && load_addr && !abort && !commit;
  assign byte_go     = idle && byte_valid && !abort && !commit && !load_addr;
  assign pend_any    = |pend_mask;
  assign commit_fire = commit_go && pend_any;

  eepw_page_buf #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .load_go(load_go), .start_addr(start_addr),
    .byte_go(byte_go), .byte_data(byte_data),
    .clear_go(abort_go || commit_go),
    .ptr(addr_ptr), .mask(pend_mask), .data_flat(wr_data)
  );

  eepw_seq #(.ROW_W(ROW_W), .PAGE(PAGE), .BUSY_CYCLES(BUSY_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .fire(commit_fire), .row_in(addr_ptr[ADDR_W-1:PAGE_BITS]), .mask_in(pend_mask),
    .busy(busy), .wr_en(wr_en), .wr_row(wr_row), .wr_mask(wr_mask)
  );

  eepw_array #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_arr (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_row(wr_row), .wr_mask(wr_mask), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: rtl/eepw_checker.sv
module eepw_checker #(
  parameter int ADDR_W      = 11,
  parameter int PAGE_BITS   = 4,
  parameter int BUSY_CYCLES = 50000,
  localparam int PAGE       = 1 << PAGE_BITS
) (
  input logic              clk,
  input logic              rst_n,
  input logic              commit,
  input logic              abort,
  input logic              busy,
  input logic              wr_en,
  input logic [PAGE-1:0]   wr_mask,
  input logic [ADDR_W-1:0] addr_ptr,
  input logic              byte_go,
  input logic              pend_any
);
  logic [PAGE_BITS-1:0]        ptr_lo;
  logic [ADDR_W-PAGE_BITS-1:0] ptr_hi;
  int unsigned                 run_len;

  assign ptr_lo = addr_ptr[PAGE_BITS-1:0];
  assign ptr_hi = addr_ptr[ADDR_W-1:PAGE_BITS];

  // Counts how many cycles busy has been high (window check without deep $past).
  always_ff @(posedge clk) begin
    if (!rst_n)    run_len <= 0;
    else if (busy) run_len <= run_len + 1;
    else           run_len <= 0;
  end

  assert_ptr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_go |=> (ptr_hi == $past(ptr_hi)) && (ptr_lo == PAGE_BITS'($past(ptr_lo) + 1'b1)));

  assert_wr_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  assert_wr_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_mask != '0));

  assert_wr_in_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy);

  assert_busy_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> wr_en);

  assert_busy_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == BUSY_CYCLES));

  assert_empty_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !abort && !busy && !pend_any) |=> !busy);

  assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(addr_ptr));
endmodule

bind eeprom_page_writer eepw_checker #(
  .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .BUSY_CYCLES(BUSY_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .commit(commit), .abort(abort), .busy(busy),
  .wr_en(wr_en), .wr_mask(wr_mask), .addr_ptr(addr_ptr),
  .byte_go(byte_go), .pend_any(pend_any)
);

// File: tb/sim_eeprom_page_writer.sv
`timescale 1ns/100ps
module sim_eeprom_page_writer;
  localparam int AW    = 6;
  localparam int PB    = 4;
  localparam int BUSYN = 20;
  localparam int PAGE  = 1 << PB;
  localparam int DEPTH = 1 << AW;
  localparam int RW    = AW - PB;

  logic            clk = 0;
  logic            rst_n = 0;
  logic            load_addr = 0, byte_valid = 0, commit = 0, abort = 0;
  logic [AW-1:0]   start_addr = '0, rd_addr = '0;
  logic [7:0]      byte_data = '0;
  logic [7:0]      rd_data;
  logic            busy, wr_en;
  logic [AW-1:0]   addr_ptr;
  logic [RW-1:0]   wr_row;
  logic [PAGE-1:0] wr_mask;
  logic [PAGE*8-1:0] wr_data;

  int checks = 0, fails = 0;
  logic [7:0]      model [DEPTH];
  logic [7:0]      pbuf [PAGE];
  logic [PAGE-1:0] pmask;
  int unsigned     mptr;

  always #2 clk = ~clk;

  eeprom_page_writer #(.ADDR_W(AW), .PAGE_BITS(PB), .BUSY_CYCLES(BUSYN)) u0 (
    .clk(clk), .rst_n(rst_n), .load_addr(load_addr), .start_addr(start_addr),
    .byte_valid(byte_valid), .byte_data(byte_data), .commit(commit), .abort(abort),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .addr_ptr(addr_ptr),
    .wr_en(wr_en), .wr_row(wr_row), .wr_mask(wr_mask), .wr_data(wr_data)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int unsigned nxt(input int unsigned p);
    return (p / PAGE) * PAGE + ((p % PAGE) + 1) % PAGE;
  endfunction

  task automatic pulse_load(input int unsigned a);
    @(negedge clk); load_addr = 1; start_addr = AW'(a);
    @(negedge clk); load_addr = 0;
    mptr = a; pmask = '0;
  endtask

  task automatic send_byte(input logic [7:0] d);
    @(negedge clk); byte_valid = 1; byte_data = d;
    @(negedge clk); byte_valid = 0;
    pbuf[mptr % PAGE] = d; pmask[mptr % PAGE] = 1'b1; mptr = nxt(mptr);
  endtask

  task automatic pulse_abort();
    @(negedge clk); abort = 1;
    @(negedge clk); abort = 0;
    pmask = '0;
  endtask

  // Commit and check the write pulse and busy window.
  task automatic do_commit(input string req);
    int blen;
    @(negedge clk); commit = 1;
    @(negedge clk); commit = 0;
    if (pmask != '0) begin
      chk(wr_en === 1'b1, "R5 wr_en after commit", longint'(wr_en), 1);
      chk(wr_row == RW'(mptr / PAGE), "R5 wr_row", longint'(wr_row), longint'(mptr / PAGE));
      chk(wr_mask == pmask, "R5 wr_mask", longint'(wr_mask), longint'(pmask));
      for (int k = 0; k < PAGE; k++)
        if (pmask[k]) begin
          chk(wr_data[k*8 +: 8] == pbuf[k], "R3 slot data", longint'(wr_data[k*8 +: 8]), longint'(pbuf[k]));
          model[(mptr / PAGE) * PAGE + k] = pbuf[k];
        end
      blen = 0;
      while (busy === 1'b1 && blen < 10 * BUSYN) begin
        blen++;
        @(negedge clk);
        if (blen == 1) chk(wr_en === 1'b0, "R5 wr_en single cycle", longint'(wr_en), 0);
      end
      chk(blen == BUSYN, "R6 busy length", blen, BUSYN);
    end else begin
      for (int c = 0; c < 4; c++) begin
        chk(busy === 1'b0 && wr_en === 1'b0, {"R7 no write ", req}, longint'(busy), 0);
        @(negedge clk);
      end
    end
    chk(addr_ptr == AW'(mptr), "R9 pointer after commit", longint'(addr_ptr), longint'(mptr));
    pmask = '0;
  endtask

  task automatic check_array(input string req);
    int bad;
    bad = 0;
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk); rd_addr = AW'(a); #1;
      if (rd_data !== model[a]) begin
        bad++;
        $display("FAIL %s addr=%0h actual=%0h expected=%0h", req, a, rd_data, model[a]);
      end
    end
    checks++;
    if (bad != 0) fails++;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R6 watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    int counts [4] = '{1, 3, 16, 19};
    int starts [3] = '{0, 7, 15};
    for (int a = 0; a < DEPTH; a++) model[a] = 8'hFF;
    pmask = '0; mptr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk(busy === 1'b0, "R1 busy", longint'(busy), 0);
    chk(wr_en === 1'b0, "R1 wr_en", longint'(wr_en), 0);
    chk(addr_ptr == '0, "R1 addr_ptr", longint'(addr_ptr), 0);
    check_array("R1 initial FF");

    // R2 R3 R5 R9 sweep over rows, start offsets and burst lengths
    for (int r = 0; r < (1 << RW); r++)
      for (int si = 0; si < 3; si++)
        for (int ci = 0; ci < 4; ci++) begin
          int unsigned sa;
          sa = r * PAGE + starts[si];
          pulse_load(sa);
          for (int i = 0; i < counts[ci]; i++) begin
            send_byte(8'((r * 37 + si * 11 + ci * 5 + i * 13 + 1)));
            chk(addr_ptr == AW'(mptr), "R2 pointer step", longint'(addr_ptr), longint'(mptr));
          end
          // R4: nothing written before commit
          rd_addr = AW'(sa); #1;
          chk(rd_data == model[sa] && wr_en === 1'b0, "R4 no early write", longint'(rd_data), longint'(model[sa]));
          do_commit("sweep");
          if (counts[ci] == 1) check_array("R10 single byte write");
          else check_array("R5 page write array");
        end

    // R7: empty commit
    pulse_load(5);
    do_commit("empty");
    check_array("R7 empty commit array");

    // R7: abort then commit
    pulse_load(34);
    send_byte(8'hA5); send_byte(8'h3C);
    pulse_abort();
    do_commit("after abort");
    check_array("R7 abort array");

    // R8: strobes during busy are ignored
    pulse_load(18);
    send_byte(8'h11); send_byte(8'h22); send_byte(8'h33);
    @(negedge clk); commit = 1;
    @(negedge clk); commit = 0;
    for (int k = 0; k < 3; k++) model[18 + k] = 8'(8'h11 * (k + 1));
    for (int c = 0; c < BUSYN - 4; c++) begin
      byte_valid = 1; byte_data = 8'h5A;
      load_addr = (c % 3 == 0); start_addr = 6'd40;
      commit = (c % 5 == 1); abort = (c % 7 == 2);
      @(negedge clk);
    end
    byte_valid = 0; load_addr = 0; commit = 0; abort = 0;
    while (busy === 1'b1) @(negedge clk);
    chk(addr_ptr == AW'(21), "R8 pointer untouched in busy", longint'(addr_ptr), 21);
    pmask = '0; mptr = 21;
    do_commit("R8 stray bytes not latched");
    check_array("R8 array after busy strobes");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule